// File: doc/BRIEF.md
# SMBus host transaction sequencer

This block is the protocol layer of an SMBus host. Software loads a target address byte, a command byte and two data bytes through a small write port. It then writes the control register with the start bit set and a protocol number. The sequencer walks a fixed script of byte-level primitives for that protocol and hands them one at a time to a lower bus engine. The primitives are start, repeated start, transmit byte, receive byte followed by ACK, receive byte followed by NACK, and stop. The engine produces all bit timing on the wires and acknowledges each primitive with a one-cycle done pulse.

Received bytes land in the two data registers. The outcome of each transaction is reported in a status register whose sticky flags are cleared by writing ones. The outcome is one of: completed, target did not acknowledge, bus lost, or aborted. An interrupt output follows the enabled outcome flags.

Register select codes are 0 address, 1 command, 2 data 0, 3 data 1, 4 control and 5 status. In the control byte, bit 0 enables the interrupt, bit 1 is the kill request, bits 4:2 hold the protocol number and bit 6 is the start request. The status byte is read directly from `status_o`. Its bits are: bit 0 busy, bit 1 complete, bit 2 device error, bit 3 bus error, bit 4 failed, bit 5 in use, bit 6 alert, and bit 7, which always reads 0.

Top module: `smb_txn_host`

## Requirements
- R1: The transmitted address byte is the address register's upper 7 bits with a direction bit in bit 0. Quick and byte protocols use the register's own bit 0. The first address of the byte-data, word-data and process-call protocols always carries 0 (write). The address sent after a repeated start always carries 1 (read).
- R2: Protocol 0 (quick) issues start, transmit of the address byte, then stop, and nothing else.
- R3: Protocol 1 (byte) with direction 0 transmits the command register after the address. With direction 1 it receives one byte with NACK into data 0.
- R4: Protocol 2 (byte data) transmits the command, then either transmits data 0 or does a repeated start, a read address and a NACKed receive into data 0.
- R5: Protocol 3 (word data) moves data 0 first and data 1 second. On a read, the first byte is ACKed and the second is NACKed.
- R6: Protocol 4 (process call) transmits address (write), command, data 0 and data 1. It then does a repeated start and a read address, and receives data 0 with ACK and data 1 with NACK, ignoring the address register's bit 0.
- R7: A start with protocol number 5, 6 or 7 issues no primitive, never raises busy and sets the failed flag (bit 4).
- R8: Busy (bit 0) rises the cycle after an accepted start and falls the cycle after the final primitive's done. A start written while busy is ignored.
- R9: A NACK reported on any transmitted byte ends the script with a stop and sets device error (bit 2), not complete (bit 1).
- R10: A bus-lost report on any primitive ends the transaction at once with no stop, sets bus error (bit 3) and drops the request.
- R11: Writing the kill bit while busy lets the current primitive finish, then issues stop and sets failed (bit 4) instead of complete. Writing it while idle has no effect.
- R12: Status flags 1 to 6 are sticky and cleared by writing 1 to their bit position. In use (bit 5) is set by every accepted start, and alert (bit 6) is set while the alert input is high.
- R13: The interrupt output equals the interrupt enable ANDed with the OR of complete, device error, bus error and failed. Alert does not raise it.
- R14: The request stays high with a stable operation code until done. Operation codes are 0 start, 1 repeated start, 2 transmit, 3 receive with ACK, 4 receive with NACK and 5 stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| alert_i | input | 1 | Alert line from the bus, active high |
| eng_done_i | input | 1 | Engine finished the requested primitive (one cycle) |
| eng_nack_i | input | 1 | Target did not acknowledge the transmitted byte |
| eng_lost_i | input | 1 | Bus collision or arbitration loss during the primitive |
| eng_rx_i | input | 8 | Byte received by the engine |
| status_o | output | 8 | Status byte |
| data0_o | output | 8 | Data register 0 |
| data1_o | output | 8 | Data register 1 |
| irq_o | output | 1 | Interrupt request |
| eng_req_o | output | 1 | Primitive request to the engine |
| eng_op_o | output | 3 | Primitive operation code |
| eng_tx_o | output | 8 | Byte to transmit |

## Verification
The assertions assume the engine raises done only while a request is pending and for a single cycle. They also assume the done, NACK and lost indications arrive together in that cycle. The operation hold check further assumes software leaves the address, command and data registers alone while busy, because the transmitted byte is read live from them. The bench's engine model answers after a programmable latency and only when it sees a request. The bench writes the byte registers only between transactions, except for the deliberate start and kill writes that test R8 and R11.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;
    localparam int OP_W   = 3;
    localparam int PROT_W = 3;
    localparam int STEP_W = 4;
    localparam int FLAG_N = 6;

    localparam logic [SEL_W-1:0] RS_ADDR = 3'd0;
    localparam logic [SEL_W-1:0] RS_CMD  = 3'd1;
    localparam logic [SEL_W-1:0] RS_D0   = 3'd2;
    localparam logic [SEL_W-1:0] RS_D1   = 3'd3;
    localparam logic [SEL_W-1:0] RS_CTRL = 3'd4;
    localparam logic [SEL_W-1:0] RS_STAT = 3'd5;

    localparam int CB_IEN   = 0;
    localparam int CB_KILL  = 1;
    localparam int CB_PLO   = 2;
    localparam int CB_START = 6;

    localparam logic [PROT_W-1:0] LAST_PROTO = 3'd4;

    typedef enum logic [OP_W-1:0] {
        OP_START   = 3'd0,
        OP_RSTART  = 3'd1,
        OP_TX      = 3'd2,
        OP_RX_ACK  = 3'd3,
        OP_RX_NACK = 3'd4,
        OP_STOP    = 3'd5
    } bus_op_e;

    typedef enum logic [2:0] {
        BS_NONE, BS_ADDR_RW, BS_ADDR_W, BS_ADDR_R, BS_CMD, BS_D0, BS_D1
    } byte_src_e;

    typedef struct packed {
        bus_op_e   op;
        byte_src_e src;
    } step_t;

    function automatic step_t mk(input bus_op_e o, input byte_src_e b);
        step_t r;
        r.op  = o;
        r.src = b;
        return r;
    endfunction

    function automatic logic proto_ok(input logic [PROT_W-1:0] p);
        return p <= LAST_PROTO;
    endfunction

    // Read tail shared by byte/word data reads and process call.
    function automatic step_t read_tail(input logic [STEP_W-1:0] k, input logic two);
        step_t r;
        r = mk(OP_STOP, BS_NONE);
        case (k)
            4'd0: r = mk(OP_RSTART, BS_NONE);
            4'd1: r = mk(OP_TX, BS_ADDR_R);
            4'd2: r = two ? mk(OP_RX_ACK, BS_D0) : mk(OP_RX_NACK, BS_D0);
            4'd3: if (two) r = mk(OP_RX_NACK, BS_D1);
            default: ;
        endcase
        return r;
    endfunction

    // Script entry for a protocol, direction and step; past the end -> stop.
    function automatic step_t script_step(input logic [PROT_W-1:0] p,
                                          input logic rd,
                                          input logic [STEP_W-1:0] s);
        step_t r;
        r = mk(OP_STOP, BS_NONE);
        if (s == '0) begin
            r = mk(OP_START, BS_NONE);
        end else if (p == 3'd0) begin
            if (s == 4'd1) r = mk(OP_TX, BS_ADDR_RW);
        end else if (p == 3'd1) begin
            if (s == 4'd1) r = mk(OP_TX, BS_ADDR_RW);
            else if (s == 4'd2) begin
                if (rd) r = mk(OP_RX_NACK, BS_D0);
                else    r = mk(OP_TX, BS_CMD);
            end
        end else begin
            if (s == 4'd1)      r = mk(OP_TX, BS_ADDR_W);
            else if (s == 4'd2) r = mk(OP_TX, BS_CMD);
            else if (p == 3'd4) begin
                if (s == 4'd3)      r = mk(OP_TX, BS_D0);
                else if (s == 4'd4) r = mk(OP_TX, BS_D1);
                else if (s >= 4'd5) r = read_tail(s - 4'd5, 1'b1);
            end else if (rd) begin
                r = read_tail(s - 4'd3, p == 3'd3);
            end else begin
                if (s == 4'd3)                   r = mk(OP_TX, BS_D0);
                else if (s == 4'd4 && p == 3'd3) r = mk(OP_TX, BS_D1);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we_i,
    input  logic [SEL_W-1:0]  reg_sel_i,
    input  logic [BYTE_W-1:0] reg_wdata_i,
    input  logic              alert_i,
    input  logic              busy_i,
    input  logic              ev_done_i,
    input  logic              ev_dev_i,
    input  logic              ev_bus_i,
    input  logic              ev_fail_i,
    input  logic              rx_we_i,
    input  logic              rx_hi_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  byte_src_e         tx_src_i,
    output logic              start_o,
    output logic [PROT_W-1:0] start_proto_o,
    output logic              start_rd_o,
    output logic              kill_o,
    output logic [BYTE_W-1:0] tx_byte_o,
    output logic [BYTE_W-1:0] status_o,
    output logic [BYTE_W-1:0] data0_o,
    output logic [BYTE_W-1:0] data1_o,
    output logic              irq_o
);

    logic [BYTE_W-1:0] addr_q, cmd_q, d0_q, d1_q;
    logic              ien_q;
    logic [FLAG_N:1]   flag_q, flag_set, flag_clr;
    logic              ctrl_wr;

    assign ctrl_wr       = reg_we_i && (reg_sel_i == RS_CTRL);
    assign start_o       = ctrl_wr && reg_wdata_i[CB_START] && !busy_i;
    assign kill_o        = ctrl_wr && reg_wdata_i[CB_KILL] && busy_i;
    assign start_proto_o = reg_wdata_i[CB_PLO +: PROT_W];
    assign start_rd_o    = addr_q[0];

    assign flag_set = {alert_i, start_o, ev_fail_i, ev_bus_i, ev_dev_i, ev_done_i};
    assign flag_clr = (reg_we_i && reg_sel_i == RS_STAT) ? reg_wdata_i[FLAG_N:1] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cmd_q  <= '0;
            d0_q   <= '0;
            d1_q   <= '0;
            ien_q  <= 1'b0;
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~flag_clr) | flag_set;
            if (ctrl_wr) ien_q <= reg_wdata_i[CB_IEN];
            if (reg_we_i && reg_sel_i == RS_ADDR) addr_q <= reg_wdata_i;
            if (reg_we_i && reg_sel_i == RS_CMD)  cmd_q  <= reg_wdata_i;
            if (rx_we_i && !rx_hi_i)                   d0_q <= rx_data_i;
            else if (reg_we_i && reg_sel_i == RS_D0)   d0_q <= reg_wdata_i;
            if (rx_we_i && rx_hi_i)                    d1_q <= rx_data_i;
            else if (reg_we_i && reg_sel_i == RS_D1)   d1_q <= reg_wdata_i;
        end
    end

    always_comb begin
        case (tx_src_i)
            BS_ADDR_RW: tx_byte_o = addr_q;
            BS_ADDR_W:  tx_byte_o = {addr_q[BYTE_W-1:1], 1'b0};
            BS_ADDR_R:  tx_byte_o = {addr_q[BYTE_W-1:1], 1'b1};
            BS_CMD:     tx_byte_o = cmd_q;
            BS_D0:      tx_byte_o = d0_q;
            BS_D1:      tx_byte_o = d1_q;
            default:    tx_byte_o = '0;
        endcase
    end

    assign status_o = {1'b0, flag_q, busy_i};
    assign data0_o  = d0_q;
    assign data1_o  = d1_q;
    assign irq_o    = ien_q && (|flag_q[4:1]);

    // R9
    single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_done_i, ev_dev_i, ev_bus_i, ev_fail_i}));

    // R12
    inuse_set_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |=> status_o[5]);

endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
    import smb_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [PROT_W-1:0] start_proto_i,
    input  logic              start_rd_i,
    input  logic              kill_i,
    input  logic              eng_done_i,
    input  logic              eng_nack_i,
    input  logic              eng_lost_i,
    output logic              busy_o,
    output logic              eng_req_o,
    output bus_op_e           eng_op_o,
    output byte_src_e         eng_src_o,
    output logic              ev_done_o,
    output logic              ev_dev_o,
    output logic              ev_bus_o,
    output logic              ev_fail_o,
    output logic              rx_we_o,
    output logic              rx_hi_o
);

    typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_HALT} seq_state_e;

    seq_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    logic [PROT_W-1:0] proto_q;
    logic              rd_q, kill_q, dev_q;
    step_t             cur;
    logic              act, lost, fin, nack;

    assign cur = (state_q == SQ_HALT) ? mk(OP_STOP, BS_NONE)
                                      : script_step(proto_q, rd_q, step_q);

    assign act  = (state_q != SQ_IDLE) && eng_done_i;
    assign lost = act && eng_lost_i;
    assign fin  = act && !eng_lost_i && cur.op == OP_STOP;
    assign nack = act && !eng_lost_i && cur.op == OP_TX && eng_nack_i;

    assign busy_o    = state_q != SQ_IDLE;
    assign eng_req_o = busy_o;
    assign eng_op_o  = cur.op;
    assign eng_src_o = cur.src;
    assign rx_we_o   = act && !eng_lost_i && (cur.op == OP_RX_ACK || cur.op == OP_RX_NACK);
    assign rx_hi_o   = cur.src == BS_D1;

    assign ev_bus_o  = lost;
    assign ev_fail_o = (fin && kill_q) ||
                       (state_q == SQ_IDLE && start_i && !proto_ok(start_proto_i));
    assign ev_dev_o  = fin && !kill_q && dev_q;
    assign ev_done_o = fin && !kill_q && !dev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            step_q  <= '0;
            proto_q <= '0;
            rd_q    <= 1'b0;
            kill_q  <= 1'b0;
            dev_q   <= 1'b0;
        end else if (state_q == SQ_IDLE) begin
            if (start_i && proto_ok(start_proto_i)) begin
                state_q <= SQ_RUN;
                step_q  <= '0;
                proto_q <= start_proto_i;
                rd_q    <= start_rd_i;
                kill_q  <= 1'b0;
                dev_q   <= 1'b0;
            end
        end else begin
            if (kill_i) kill_q <= 1'b1;
            if (eng_done_i) begin
                if (lost || fin) begin
                    state_q <= SQ_IDLE;
                end else if (nack) begin
                    state_q <= SQ_HALT;
                    dev_q   <= 1'b1;
                end else if (kill_q || kill_i) begin
                    state_q <= SQ_HALT;
                end else begin
                    step_q <= step_q + STEP_W'(1);
                end
            end
        end
    end

    // R14
    op_hold_chk: assert property (@(posedge clk) disable iff (rst)
        eng_req_o && !eng_done_i |=> eng_req_o && $stable(eng_op_o));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o && !start_i |=> !busy_o);

    // R10
    lost_release_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o && eng_done_i && eng_lost_i |=> !eng_req_o);

    // R7
    bad_proto_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o && start_i && (start_proto_i > LAST_PROTO) |=> !busy_o);

endmodule

// File: rtl/smb_txn_host.sv
module smb_txn_host
    import smb_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we_i,
    input  logic [SEL_W-1:0]  reg_sel_i,
    input  logic [BYTE_W-1:0] reg_wdata_i,
    input  logic              alert_i,
    input  logic              eng_done_i,
    input  logic              eng_nack_i,
    input  logic              eng_lost_i,
    input  logic [BYTE_W-1:0] eng_rx_i,
    output logic [BYTE_W-1:0] status_o,
    output logic [BYTE_W-1:0] data0_o,
    output logic [BYTE_W-1:0] data1_o,
    output logic              irq_o,
    output logic              eng_req_o,
    output logic [OP_W-1:0]   eng_op_o,
    output logic [BYTE_W-1:0] eng_tx_o
);

    logic              start, start_rd, kill, busy;
    logic [PROT_W-1:0] start_proto;
    logic              ev_done, ev_dev, ev_bus, ev_fail, rx_we, rx_hi;
    bus_op_e           op;
    byte_src_e         src;

    smb_host_regs regs_i (
        .clk           (clk),
        .rst           (rst),
        .reg_we_i      (reg_we_i),
        .reg_sel_i     (reg_sel_i),
        .reg_wdata_i   (reg_wdata_i),
        .alert_i       (alert_i),
        .busy_i        (busy),
        .ev_done_i     (ev_done),
        .ev_dev_i      (ev_dev),
        .ev_bus_i      (ev_bus),
        .ev_fail_i     (ev_fail),
        .rx_we_i       (rx_we),
        .rx_hi_i       (rx_hi),
        .rx_data_i     (eng_rx_i),
        .tx_src_i      (src),
        .start_o       (start),
        .start_proto_o (start_proto),
        .start_rd_o    (start_rd),
        .kill_o        (kill),
        .tx_byte_o     (eng_tx_o),
        .status_o      (status_o),
        .data0_o       (data0_o),
        .data1_o       (data1_o),
        .irq_o         (irq_o)
    );

    smb_host_seq seq_i (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .start_proto_i (start_proto),
        .start_rd_i    (start_rd),
        .kill_i        (kill),
        .eng_done_i    (eng_done_i),
        .eng_nack_i    (eng_nack_i),
        .eng_lost_i    (eng_lost_i),
        .busy_o        (busy),
        .eng_req_o     (eng_req_o),
        .eng_op_o      (op),
        .eng_src_o     (src),
        .ev_done_o     (ev_done),
        .ev_dev_o      (ev_dev),
        .ev_bus_o      (ev_bus),
        .ev_fail_o     (ev_fail),
        .rx_we_o       (rx_we),
        .rx_hi_o       (rx_hi)
    );

    assign eng_op_o = op;

endmodule

// File: tb/smb_txn_host_tb.sv
module smb_txn_host_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic       alert = 1'b0;
    logic       eng_done = 1'b0, eng_nack = 1'b0, eng_lost = 1'b0;
    logic [7:0] eng_rx = '0;
    logic [7:0] status, data0, data1, eng_tx;
    logic       irq, eng_req;
    logic [2:0] eng_op;

    always #10 clk = ~clk;

    smb_txn_host dut_i (
        .clk(clk), .rst(rst), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
        .reg_wdata_i(reg_wdata), .alert_i(alert), .eng_done_i(eng_done),
        .eng_nack_i(eng_nack), .eng_lost_i(eng_lost), .eng_rx_i(eng_rx),
        .status_o(status), .data0_o(data0), .data1_o(data1), .irq_o(irq),
        .eng_req_o(eng_req), .eng_op_o(eng_op), .eng_tx_o(eng_tx)
    );

    localparam logic [2:0] S = 3'd0, RS = 3'd1, TX = 3'd2, RA = 3'd3, RN = 3'd4, P = 3'd5;

    int checks = 0, errors = 0;
    logic [10:0] got_q[$];
    logic [10:0] exp_q[$];
    logic [7:0]  rx_q[$];
    int   lat = 1, nack_at = -1, lost_at = -1, tx_seen = 0, wcnt = 0;
    logic final_hit = 1'b0;
    logic exp_busy = 1'b0;
    logic nb;

    // Bus engine model: answers each request after lat idle cycles.
    always @(negedge clk) begin
        if (rst) begin
            eng_done = 0; eng_nack = 0; eng_lost = 0; wcnt = 0; final_hit = 0;
        end else if (eng_done) begin
            eng_done = 0; eng_nack = 0; eng_lost = 0; final_hit = 0; wcnt = 0;
        end else if (eng_req) begin
            if (wcnt >= lat) begin
                got_q.push_back({eng_op, (eng_op == TX) ? eng_tx : 8'h00});
                final_hit = (eng_op == P);
                if (eng_op == TX) begin
                    if (tx_seen == nack_at) eng_nack = 1;
                    if (tx_seen == lost_at) begin eng_lost = 1; final_hit = 1; end
                    tx_seen++;
                end
                if (eng_op == RA || eng_op == RN)
                    eng_rx = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hEE;
                eng_done = 1;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    // Behavioural busy model compared every clock (R8).
    always @(posedge clk) begin
        #1;
        if (rst) begin
            exp_busy = 0;
        end else begin
            nb = exp_busy;
            if (reg_we && reg_sel == 3'd4 && reg_wdata[6] && reg_wdata[4:2] <= 3'd4 && !exp_busy)
                nb = 1;
            if (eng_done && final_hit) nb = 0;
            exp_busy = nb;
            checks++;
            if (status[0] !== exp_busy) begin
                errors++;
                $display("FAIL R8 busy act=%0b exp=%0b at %0t", status[0], exp_busy, $time);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic ex(input logic [2:0] o, input logic [7:0] b);
        exp_q.push_back({o, b});
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 5000 && status[0]; g++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input logic [2:0] proto, input logic ien);
        got_q.delete();
        tx_seen = 0;
        wr(3'd4, {1'b0, 1'b1, 1'b0, proto, 1'b0, ien});
        wait_idle();
    endtask

    task automatic cmp_log(input string tag);
        logic bad;
        bad = 0;
        checks++;
        if (got_q.size() != exp_q.size()) begin
            errors++;
            $display("FAIL %s primitive count act=%0d exp=%0d", tag, got_q.size(), exp_q.size());
        end else begin
            foreach (exp_q[i]) begin
                if (!bad && got_q[i] !== exp_q[i]) begin
                    bad = 1;
                    errors++;
                    $display("FAIL %s primitive %0d act=%0h exp=%0h", tag, i, got_q[i], exp_q[i]);
                end
            end
        end
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R12 reset status", status, 8'h00);
        chk("R13 reset irq", irq, 0);
        chk("R14 reset request", eng_req, 0);

        wr(3'd0, 8'hA0); wr(3'd1, 8'h5A); wr(3'd2, 8'h11); wr(3'd3, 8'h22);

        // R2 quick write
        run(3'd0, 1'b0);
        ex(S, 0); ex(TX, 8'hA0); ex(P, 0);
        cmp_log("R2 quick write");
        chk("R12 complete and in-use", status, 8'h22);
        chk("R13 irq disabled", irq, 0);
        wr(3'd5, 8'h02);
        chk("R12 clear only complete", status, 8'h20);
        wr(3'd5, 8'hFF);
        chk("R12 clear all", status, 8'h00);

        // R1 quick read keeps bit 0
        wr(3'd0, 8'hA1);
        run(3'd0, 1'b0);
        ex(S, 0); ex(TX, 8'hA1); ex(P, 0);
        cmp_log("R1 quick read address");

        // R3 byte read
        rx_q.push_back(8'h3C);
        run(3'd1, 1'b0);
        ex(S, 0); ex(TX, 8'hA1); ex(RN, 0); ex(P, 0);
        cmp_log("R3 byte read script");
        chk("R3 byte read data0", data0, 8'h3C);

        // R3 byte write
        wr(3'd0, 8'hA0);
        run(3'd1, 1'b0);
        ex(S, 0); ex(TX, 8'hA0); ex(TX, 8'h5A); ex(P, 0);
        cmp_log("R3 byte write script");

        // R4 byte data write and read
        wr(3'd2, 8'h11);
        run(3'd2, 1'b0);
        ex(S, 0); ex(TX, 8'hA0); ex(TX, 8'h5A); ex(TX, 8'h11); ex(P, 0);
        cmp_log("R4 byte data write");
        wr(3'd0, 8'hA1);
        rx_q.push_back(8'h77);
        run(3'd2, 1'b0);
        ex(S, 0); ex(TX, 8'hA0); ex(TX, 8'h5A); ex(RS, 0); ex(TX, 8'hA1); ex(RN, 0); ex(P, 0);
        cmp_log("R4 R1 byte data read");
        chk("R4 byte data read data0", data0, 8'h77);

        // R5 word data write and read
        wr(3'd0, 8'hA0); wr(3'd2, 8'h11); wr(3'd3, 8'h22);
        run(3'd3, 1'b0);
        ex(S, 0); ex(TX, 8'hA0); ex(TX, 8'h5A); ex(TX, 8'h11); ex(TX, 8'h22); ex(P, 0);
        cmp_log("R5 word write low first");
        wr(3'd0, 8'hA1);
        rx_q.push_back(8'h34); rx_q.push_back(8'h12);
        run(3'd3, 1'b0);
        ex(S, 0); ex(TX, 8'hA0); ex(TX, 8'h5A); ex(RS, 0); ex(TX, 8'hA1); ex(RA, 0); ex(RN, 0); ex(P, 0);
        cmp_log("R5 word read script");
        chk("R5 word read data0", data0, 8'h34);
        chk("R5 word read data1", data1, 8'h12);

        // R6 process call (address bit 0 is 1, still writes first)
        wr(3'd2, 8'hAB); wr(3'd3, 8'hCD);
        rx_q.push_back(8'h55); rx_q.push_back(8'h66);
        run(3'd4, 1'b0);
        ex(S, 0); ex(TX, 8'hA0); ex(TX, 8'h5A); ex(TX, 8'hAB); ex(TX, 8'hCD);
        ex(RS, 0); ex(TX, 8'hA1); ex(RA, 0); ex(RN, 0); ex(P, 0);
        cmp_log("R6 process call script");
        chk("R6 process call data0", data0, 8'h55);
        chk("R6 process call data1", data1, 8'h66);
        wr(3'd5, 8'hFF);

        // R9 NACK on address, interrupt enabled
        wr(3'd0, 8'hA0);
        nack_at = 0;
        run(3'd1, 1'b1);
        ex(S, 0); ex(TX, 8'hA0); ex(P, 0);
        cmp_log("R9 address nack stops");
        chk("R9 device error flag", status, 8'h24);
        chk("R13 irq on device error", irq, 1);
        wr(3'd5, 8'hFF);
        chk("R13 irq cleared", irq, 0);

        // R9 NACK on command byte
        nack_at = 1;
        wr(3'd2, 8'h11);
        run(3'd2, 1'b0);
        ex(S, 0); ex(TX, 8'hA0); ex(TX, 8'h5A); ex(P, 0);
        cmp_log("R9 command nack stops");
        chk("R9 command nack flag", status, 8'h24);
        nack_at = -1;
        wr(3'd5, 8'hFF);

        // R10 bus lost on address
        lost_at = 0;
        run(3'd3, 1'b0);
        ex(S, 0); ex(TX, 8'hA0);
        cmp_log("R10 lost no stop");
        chk("R10 bus error flag", status, 8'h28);
        chk("R10 request released", eng_req, 0);
        lost_at = -1;
        wr(3'd5, 8'hFF);

        // R11 kill during the start primitive
        lat = 6;
        got_q.delete(); tx_seen = 0;
        wr(3'd4, 8'h4C);
        wr(3'd4, 8'h02);
        wait_idle();
        ex(S, 0); ex(P, 0);
        cmp_log("R11 kill then stop");
        chk("R11 failed flag", status, 8'h30);
        lat = 1;
        wr(3'd5, 8'hFF);

        // R11 kill while idle
        got_q.delete();
        wr(3'd4, 8'h02);
        @(negedge clk);
        chk("R11 idle kill status", status, 8'h00);
        chk("R11 idle kill no request", got_q.size(), 0);

        // R7 unsupported protocols
        run(3'd5, 1'b0);
        cmp_log("R7 protocol 5 no primitives");
        chk("R7 protocol 5 failed", status, 8'h30);
        wr(3'd5, 8'hFF);
        run(3'd6, 1'b0);
        cmp_log("R7 protocol 6 no primitives");
        chk("R7 protocol 6 failed", status, 8'h30);
        wr(3'd5, 8'hFF);

        // R8 start while busy ignored
        lat = 4;
        wr(3'd2, 8'h11); wr(3'd3, 8'h22);
        got_q.delete(); tx_seen = 0;
        wr(3'd4, 8'h4C);
        wr(3'd4, 8'h40);
        wait_idle();
        ex(S, 0); ex(TX, 8'hA0); ex(TX, 8'h5A); ex(TX, 8'h11); ex(TX, 8'h22); ex(P, 0);
        cmp_log("R8 second start ignored");
        chk("R8 single completion", status, 8'h22);
        lat = 1;
        wr(3'd5, 8'hFF);

        // R12 alert flag, R13 alert does not interrupt
        wr(3'd4, 8'h01);
        @(negedge clk); alert = 1;
        @(negedge clk); alert = 0;
        @(negedge clk);
        chk("R12 alert flag", status, 8'h40);
        chk("R13 alert no irq", irq, 0);
        wr(3'd5, 8'hFF);
        chk("R12 alert cleared", status, 8'h00);

        // R13 completion with interrupt enabled
        run(3'd0, 1'b1);
        ex(S, 0); ex(TX, 8'hA0); ex(P, 0);
        cmp_log("R14 quick op codes");
        chk("R13 irq on complete", irq, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule